// File: doc/BRIEF.md
# VLIW Instruction Issue Port

This block is an AXI-Lite slave that lets a host hand 64-bit VLIW instructions to an accelerator controller over a 32-bit bus. The host writes the instruction in two halves. The lower half goes into a holding register and starts nothing. The upper half is merged with the held lower half, and the complete instruction appears on a 64-bit command output together with a one-cycle valid strobe. The bus response for that write comes back one cycle after both the address and the data have arrived. It never waits for the controller to finish executing.

A read-only status word shows three flags. BUSY covers the interval from an issue until the controller pulses its completion input. DONE marks a completed operation. ERR is a sticky flag that records an upper-half write arriving while BUSY was set. These flags are derived from the issue, reject and completion events. Software cannot write them.

Word offsets are parameters. By default the lower half sits at 0x00, the upper half at 0x04 and the status word at 0x08. The address bits [1:0] are ignored.

Top module: `vip_issue_port`

## Requirements
- R1: After reset the command valid strobe is low, both holding words are zero, the B and R channels are idle, and the status word reads 0x00000000.
- R2: A write to offset 0x00 merges the byte-strobed data into the lower holding word, does not pulse the command strobe, and receives an OKAY (2'b00) response.
- R3: A write to offset 0x04 while BUSY is clear raises the command valid strobe for exactly one cycle. In that cycle the command carries the new upper word in bits [63:32] and the held lower word in bits [31:0]. The write receives an OKAY response.
- R4: The lower holding word keeps its value across issues. Two upper-word writes with no lower-word write between them carry the same bits [31:0].
- R5: Reading offset 0x08 returns BUSY in bit 0, DONE in bit 1 and ERR in bit 2, with bits 31:3 zero. An issue sets BUSY and clears DONE. A completion pulse while BUSY is set clears BUSY on the next clock and sets DONE.
- R6: A write to offset 0x04 while BUSY is set still gets an OKAY response, but it raises no strobe and leaves the upper holding word unchanged. It sets ERR (bit 2), and ERR stays set until the next successful issue clears it.
- R7: The address and data channels are accepted independently and in either order. No write response appears until both have arrived. The response follows one cycle after the later of the two, whether or not the controller is busy.
- R8: A write to offset 0x08 or to an unmapped offset receives SLVERR (2'b10) and changes neither holding word nor any status flag.
- R9: A read of offset 0x00, 0x04 or an unmapped offset returns zero with an OKAY response.
- R10: Byte strobes select which bytes of a holding word a write updates. Bytes whose strobe is low keep their previous value, and this applies to both halves.
- R11: A completion pulse while BUSY is clear changes no status flag.
- R12: A write response and a read response, once valid, hold their valid flag and their payload stable until the host accepts them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read response valid |
| s_rready | input | 1 | Read response ready |
| cmd_instr | output | 2*DATA_W | Issued 64-bit instruction |
| cmd_valid | output | 1 | One-cycle issue strobe |
| cmd_done | input | 1 | Completion pulse from the controller |

## Verification
The bench builds the block with its defaults: ADDR_W=6, DATA_W=32 and the three offsets at 0x00, 0x04 and 0x08. A 6-bit address makes 0x0C and the top word 0x3C reachable as unmapped offsets, which exercises the SLVERR path and the zero-read path alongside the three mapped words. A 32-bit data width gives four byte strobes per half, so partial-strobe merges into both the lower and the upper holding word are visible in the issued 64-bit command.

// File: rtl/vip_pkg.sv
package vip_pkg;
  typedef logic [1:0] resp_t;
  localparam resp_t RESP_OKAY   = 2'b00;
  localparam resp_t RESP_SLVERR = 2'b10;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_t;

  localparam int ST_BUSY_BIT = 0;
  localparam int ST_DONE_BIT = 1;
  localparam int ST_ERR_BIT  = 2;
endpackage

// File: rtl/vip_wr_capture.sv
module vip_wr_capture
  import vip_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output resp_t             bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output logic [STRB_W-1:0] commit_strb,
  input  resp_t             commit_resp
);
  logic              aw_full;
  logic              w_full;
  logic [ADDR_W-1:0] aw_addr_q;
  logic [DATA_W-1:0] w_data_q;
  logic [STRB_W-1:0] w_strb_q;
  logic              b_valid_q;
  resp_t             b_resp_q;

  assign awready = !aw_full;
  assign wready  = !w_full;
  assign commit  = aw_full && w_full && !b_valid_q;

  assign commit_addr = aw_addr_q;
  assign commit_data = w_data_q;
  assign commit_strb = w_strb_q;
  assign bvalid      = b_valid_q;
  assign bresp       = b_resp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_full   <= 1'b0;
      aw_addr_q <= '0;
    end else if (awvalid && !aw_full) begin
      aw_full   <= 1'b1;
      aw_addr_q <= awaddr;
    end else if (commit) begin
      aw_full   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_full   <= 1'b0;
      w_data_q <= '0;
      w_strb_q <= '0;
    end else if (wvalid && !w_full) begin
      w_full   <= 1'b1;
      w_data_q <= wdata;
      w_strb_q <= wstrb;
    end else if (commit) begin
      w_full   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_valid_q <= 1'b0;
      b_resp_q  <= RESP_OKAY;
    end else if (commit) begin
      b_valid_q <= 1'b1;
      b_resp_q  <= commit_resp;
    end else if (b_valid_q && bready) begin
      b_valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vip_instr_regs.sv
module vip_instr_regs #(
  parameter int DATA_W = 32,
  localparam int STRB_W  = DATA_W / 8,
  localparam int INSTR_W = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [STRB_W-1:0]  wr_strb,
  input  logic               busy,
  output logic [INSTR_W-1:0] cmd_instr,
  output logic               cmd_valid,
  output logic               issue,
  output logic               reject
);
  logic [DATA_W-1:0]  lo_q;
  logic [DATA_W-1:0]  hi_q;
  logic [DATA_W-1:0]  lo_merge;
  logic [DATA_W-1:0]  hi_merge;
  logic [INSTR_W-1:0] instr_q;
  logic               valid_q;

  for (genvar b = 0; b < STRB_W; b++) begin : g_byte
    assign lo_merge[8*b +: 8] = wr_strb[b] ? wr_data[8*b +: 8] : lo_q[8*b +: 8];
    assign hi_merge[8*b +: 8] = wr_strb[b] ? wr_data[8*b +: 8] : hi_q[8*b +: 8];
  end

  assign issue     = wr_hi && !busy;
  assign reject    = wr_hi && busy;
  assign cmd_instr = instr_q;
  assign cmd_valid = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
    end else if (wr_lo) begin
      lo_q <= lo_merge;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      instr_q <= '0;
      valid_q <= 1'b0;
    end else if (issue) begin
      hi_q    <= hi_merge;
      instr_q <= {hi_merge, lo_q};
      valid_q <= 1'b1;
    end else begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vip_status.sv
module vip_status
  import vip_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              reject,
  input  logic              cmd_done,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] status_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else if (issue) begin
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy && cmd_done) begin
      busy <= 1'b0;
      done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= 1'b0;
    end else if (issue) begin
      err <= 1'b0;
    end else if (reject) begin
      err <= 1'b1;
    end
  end

  always_comb begin
    status_word              = '0;
    status_word[ST_BUSY_BIT] = busy;
    status_word[ST_DONE_BIT] = done;
    status_word[ST_ERR_BIT]  = err;
  end
endmodule

// File: rtl/vip_rd_port.sv
module vip_rd_port
  import vip_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int STAT_OFF = 8,
  localparam int WIDX_W  = ADDR_W - 2,
  localparam logic [WIDX_W-1:0] STAT_IDX = WIDX_W'(STAT_OFF / 4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output resp_t             rresp,
  output logic              rvalid,
  input  logic              rready,
  input  logic [DATA_W-1:0] status_word
);
  logic              r_valid_q;
  logic [DATA_W-1:0] r_data_q;

  assign arready = !r_valid_q;
  assign rvalid  = r_valid_q;
  assign rdata   = r_data_q;
  assign rresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_valid_q <= 1'b0;
      r_data_q  <= '0;
    end else if (arvalid && !r_valid_q) begin
      r_valid_q <= 1'b1;
      r_data_q  <= (araddr[ADDR_W-1:2] == STAT_IDX) ? status_word : '0;
    end else if (r_valid_q && rready) begin
      r_valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vip_issue_port.sv
module vip_issue_port
  import vip_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int LO_OFF   = 0,
  parameter int HI_OFF   = 4,
  parameter int STAT_OFF = 8,
  localparam int STRB_W  = DATA_W / 8,
  localparam int INSTR_W = 2 * DATA_W,
  localparam int WIDX_W  = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  s_awaddr,
  input  logic               s_awvalid,
  output logic               s_awready,
  input  logic [DATA_W-1:0]  s_wdata,
  input  logic [STRB_W-1:0]  s_wstrb,
  input  logic               s_wvalid,
  output logic               s_wready,
  output logic [1:0]         s_bresp,
  output logic               s_bvalid,
  input  logic               s_bready,
  input  logic [ADDR_W-1:0]  s_araddr,
  input  logic               s_arvalid,
  output logic               s_arready,
  output logic [DATA_W-1:0]  s_rdata,
  output logic [1:0]         s_rresp,
  output logic               s_rvalid,
  input  logic               s_rready,
  output logic [INSTR_W-1:0] cmd_instr,
  output logic               cmd_valid,
  input  logic               cmd_done
);
  localparam logic [WIDX_W-1:0] LO_IDX   = WIDX_W'(LO_OFF / 4);
  localparam logic [WIDX_W-1:0] HI_IDX   = WIDX_W'(HI_OFF / 4);
  localparam logic [WIDX_W-1:0] STAT_IDX = WIDX_W'(STAT_OFF / 4);

  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data;
  logic [STRB_W-1:0] commit_strb;
  resp_t             commit_resp;
  reg_sel_t          commit_sel;
  logic              wr_lo;
  logic              wr_hi;
  logic              issue;
  logic              reject;
  logic              st_busy;
  logic              st_done;
  logic              st_err;
  logic [DATA_W-1:0] status_word;

  always_comb begin
    if (commit_addr[ADDR_W-1:2] == LO_IDX)        commit_sel = SEL_LO;
    else if (commit_addr[ADDR_W-1:2] == HI_IDX)   commit_sel = SEL_HI;
    else if (commit_addr[ADDR_W-1:2] == STAT_IDX) commit_sel = SEL_STAT;
    else                                          commit_sel = SEL_NONE;
  end

  assign wr_lo       = commit && (commit_sel == SEL_LO);
  assign wr_hi       = commit && (commit_sel == SEL_HI);
  assign commit_resp = (commit_sel == SEL_LO || commit_sel == SEL_HI) ? RESP_OKAY : RESP_SLVERR;

  vip_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk         (clk),
    .rst         (rst),
    .awaddr      (s_awaddr),
    .awvalid     (s_awvalid),
    .awready     (s_awready),
    .wdata       (s_wdata),
    .wstrb       (s_wstrb),
    .wvalid      (s_wvalid),
    .wready      (s_wready),
    .bresp       (s_bresp),
    .bvalid      (s_bvalid),
    .bready      (s_bready),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .commit_strb (commit_strb),
    .commit_resp (commit_resp)
  );

  vip_instr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wr_data   (commit_data),
    .wr_strb   (commit_strb),
    .busy      (st_busy),
    .cmd_instr (cmd_instr),
    .cmd_valid (cmd_valid),
    .issue     (issue),
    .reject    (reject)
  );

  vip_status #(.DATA_W(DATA_W)) u_stat (
    .clk         (clk),
    .rst         (rst),
    .issue       (issue),
    .reject      (reject),
    .cmd_done    (cmd_done),
    .busy        (st_busy),
    .done        (st_done),
    .err         (st_err),
    .status_word (status_word)
  );

  vip_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_OFF(STAT_OFF)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .araddr      (s_araddr),
    .arvalid     (s_arvalid),
    .arready     (s_arready),
    .rdata       (s_rdata),
    .rresp       (s_rresp),
    .rvalid      (s_rvalid),
    .rready      (s_rready),
    .status_word (status_word)
  );
endmodule

// File: rtl/vip_issue_checker.sv
module vip_issue_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_done,
  input logic              busy,
  input logic              done,
  input logic              bvalid,
  input logic              bready,
  input logic [1:0]        bresp,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata
);
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  a_r5_busy_with_issue: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> busy && !done);

  a_r6_no_issue_from_busy: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !$past(busy));

  a_r5_completion_clears: assert property (@(posedge clk) disable iff (rst)
    busy && cmd_done |=> !busy && done);

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r12_b_hold: assert property (@(posedge clk) disable iff (rst)
    bvalid && !bready |=> bvalid && $stable(bresp));

  a_r12_r_hold: assert property (@(posedge clk) disable iff (rst)
    rvalid && !rready |=> rvalid && $stable(rdata));

  a_r5_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> rdata[DATA_W-1:3] == '0);
endmodule

bind vip_issue_port vip_issue_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_done  (cmd_done),
  .busy      (st_busy),
  .done      (st_done),
  .bvalid    (s_bvalid),
  .bready    (s_bready),
  .bresp     (s_bresp),
  .rvalid    (s_rvalid),
  .rready    (s_rready),
  .rdata     (s_rdata)
);

// File: tb/tb_vip_issue_port.sv
module tb_vip_issue_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  s_awaddr = '0;
  logic        s_awvalid = 1'b0;
  logic        s_awready;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_wvalid = 1'b0;
  logic        s_wready;
  logic [1:0]  s_bresp;
  logic        s_bvalid;
  logic        s_bready = 1'b0;
  logic [5:0]  s_araddr = '0;
  logic        s_arvalid = 1'b0;
  logic        s_arready;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rvalid;
  logic        s_rready = 1'b0;
  logic [63:0] cmd_instr;
  logic        cmd_valid;
  logic        cmd_done = 1'b0;

  int          n_tests = 0;
  int          n_fail  = 0;
  int          issue_cnt = 0;
  logic [63:0] last_instr = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vip_issue_port dut (
    .clk(clk), .rst(rst),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .cmd_instr(cmd_instr), .cmd_valid(cmd_valid), .cmd_done(cmd_done)
  );

  always @(posedge clk) begin
    if (cmd_valid) begin
      issue_cnt  <= issue_cnt + 1;
      last_instr <= cmd_instr;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // order: 0 both together, 1 address first, 2 data first; gap cycles before the later one
  task automatic axi_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                           input int order, input int gap, input int bwait,
                           output logic [1:0] resp, output logic early, output logic held);
    bit aw_done = 0;
    bit w_done  = 0;
    int g = gap;
    early = 1'b0;
    held  = 1'b1;
    @(negedge clk);
    s_awaddr = a[5:0];
    s_wdata  = d;
    s_wstrb  = s;
    if (order != 2) s_awvalid = 1'b1;
    if (order != 1) s_wvalid  = 1'b1;
    while (!(aw_done && w_done)) begin
      @(posedge clk);
      if (s_awvalid && s_awready) aw_done = 1;
      if (s_wvalid && s_wready) w_done = 1;
      @(negedge clk);
      if (aw_done) s_awvalid = 1'b0;
      if (w_done)  s_wvalid  = 1'b0;
      if ((aw_done && !w_done && !s_wvalid) || (w_done && !aw_done && !s_awvalid)) begin
        for (int i = 0; i < g; i++) begin
          if (s_bvalid) early = 1'b1;
          @(negedge clk);
        end
        g = 0;
        if (s_bvalid) early = 1'b1;
        if (!w_done)  s_wvalid  = 1'b1;
        if (!aw_done) s_awvalid = 1'b1;
      end
    end
    for (int i = 0; i < bwait; i++) @(negedge clk);
    if (bwait > 0 && !s_bvalid) held = 1'b0;
    s_bready = 1'b1;
    forever begin
      @(posedge clk);
      if (s_bvalid) begin
        resp = s_bresp;
        break;
      end
    end
    @(negedge clk);
    s_bready = 1'b0;
  endtask

  task automatic axi_read(input logic [7:0] a, input int rwait,
                          output logic [31:0] data, output logic [1:0] resp);
    logic [31:0] first;
    @(negedge clk);
    s_araddr  = a[5:0];
    s_arvalid = 1'b1;
    forever begin
      @(posedge clk);
      if (s_arready) break;
    end
    @(negedge clk);
    s_arvalid = 1'b0;
    first = s_rdata;
    for (int i = 0; i < rwait; i++) @(negedge clk);
    if (rwait > 0) begin
      check("R12 read data held", {31'd0, s_rvalid, s_rdata}, {31'd0, 1'b1, first});
    end
    s_rready = 1'b1;
    forever begin
      @(posedge clk);
      if (s_rvalid) begin
        data = s_rdata;
        resp = s_rresp;
        break;
      end
    end
    @(negedge clk);
    s_rready = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [1:0]  resp;
    logic        issue;
    logic [63:0] instr;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h00, 32'h11223344, 4'hF, 2'b00, 1'b0, 64'h0},
    '{8'h04, 32'hAABBCCDD, 4'hF, 2'b00, 1'b1, 64'hAABBCCDD_11223344},
    '{8'h04, 32'h01020304, 4'hF, 2'b00, 1'b1, 64'h01020304_11223344},
    '{8'h00, 32'hFFFFFFFF, 4'h3, 2'b00, 1'b0, 64'h0},
    '{8'h04, 32'h55667788, 4'hC, 2'b00, 1'b1, 64'h55660304_1122FFFF},
    '{8'h08, 32'hFFFFFFFF, 4'hF, 2'b10, 1'b0, 64'h0},
    '{8'h0C, 32'h00000000, 4'hF, 2'b10, 1'b0, 64'h0},
    '{8'h04, 32'h99999999, 4'hF, 2'b00, 1'b1, 64'h99999999_1122FFFF}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [1:0]  resp;
    logic [31:0] rd;
    logic        early;
    logic        held;
    int          base;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 cmd_valid", {63'd0, cmd_valid}, 64'd0);
    check("R1 channels idle", {62'd0, s_bvalid, s_rvalid}, 64'd0);
    axi_read(8'h08, 0, rd, resp);
    check("R1 status", {32'd0, rd}, 64'd0);
    // R11 completion while idle is ignored
    pulse_done();
    axi_read(8'h08, 0, rd, resp);
    check("R11 done while idle", {32'd0, rd}, 64'd0);

    // table walk: R2 R3 R4 R8 R10
    for (int i = 0; i < 8; i++) begin
      base = issue_cnt;
      axi_write(VECS[i].addr, VECS[i].data, VECS[i].strb, 0, 0, 0, resp, early, held);
      @(negedge clk);
      check(VECS[i].issue ? "R3 vector resp" : (VECS[i].resp == 2'b10 ? "R8 vector resp" : "R2 vector resp"),
            {62'd0, resp}, {62'd0, VECS[i].resp});
      check(VECS[i].issue ? "R3 vector strobe count" : "R2/R8 vector no strobe",
            64'(issue_cnt - base), 64'(VECS[i].issue));
      if (VECS[i].issue) begin
        check("R4 R10 vector instr", last_instr, VECS[i].instr);
        axi_read(8'h08, 0, rd, resp);
        check("R5 busy after issue", {32'd0, rd}, 64'h1);
        pulse_done();
        axi_read(8'h08, 0, rd, resp);
        check("R5 done after completion", {32'd0, rd}, 64'h2);
      end
    end

    // R9 reads of write-only and unmapped offsets
    axi_read(8'h00, 0, rd, resp);
    check("R9 read 0x00", {30'd0, resp, rd}, 64'd0);
    axi_read(8'h04, 0, rd, resp);
    check("R9 read 0x04", {30'd0, resp, rd}, 64'd0);
    axi_read(8'h3C, 0, rd, resp);
    check("R9 read 0x3C", {30'd0, resp, rd}, 64'd0);

    // R7 address first, data three cycles later; then data first
    axi_write(8'h00, 32'hCAFEF00D, 4'hF, 1, 3, 0, resp, early, held);
    check("R7 no early response (aw first)", {63'd0, early}, 64'd0);
    check("R7 resp", {62'd0, resp}, 64'd0);
    base = issue_cnt;
    axi_write(8'h04, 32'h0BADBEEF, 4'hF, 2, 4, 3, resp, early, held);
    @(negedge clk);
    check("R7 no early response (w first)", {63'd0, early}, 64'd0);
    check("R12 write response held", {63'd0, held}, 64'd1);
    check("R7 issue after late address", 64'(issue_cnt - base), 64'd1);
    check("R7 instr", last_instr, 64'h0BADBEEF_CAFEF00D);

    // R6 upper write while busy: discarded, ERR set, response immediate
    base = issue_cnt;
    axi_write(8'h04, 32'h77777777, 4'hF, 0, 0, 0, resp, early, held);
    @(negedge clk);
    check("R6 resp while busy", {62'd0, resp}, 64'd0);
    check("R6 no strobe while busy", 64'(issue_cnt - base), 64'd0);
    axi_read(8'h08, 2, rd, resp);
    check("R6 status busy+err", {32'd0, rd}, 64'h5);
    // R8 SLVERR write while busy leaves flags alone
    axi_write(8'h08, 32'h0, 4'hF, 0, 0, 0, resp, early, held);
    check("R8 status write resp", {62'd0, resp}, 64'h2);
    pulse_done();
    axi_read(8'h08, 0, rd, resp);
    check("R6 err sticky after completion", {32'd0, rd}, 64'h6);
    // R11 extra completion pulse changes nothing
    pulse_done();
    axi_read(8'h08, 0, rd, resp);
    check("R11 second completion ignored", {32'd0, rd}, 64'h6);
    // R6 next issue clears err; discarded upper word did not reach holding reg
    base = issue_cnt;
    axi_write(8'h04, 32'h12345678, 4'h1, 0, 0, 0, resp, early, held);
    @(negedge clk);
    check("R6 issue after recovery", 64'(issue_cnt - base), 64'd1);
    check("R6 R10 discarded upper bytes kept out", last_instr, 64'h0BADBE78_CAFEF00D);
    axi_read(8'h08, 0, rd, resp);
    check("R6 err cleared by issue", {32'd0, rd}, 64'h1);
    pulse_done();

    // R1 reset in mid-operation clears everything
    base = issue_cnt;
    axi_write(8'h04, 32'h1, 4'hF, 0, 0, 0, resp, early, held);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    axi_read(8'h08, 0, rd, resp);
    check("R1 status after reset", {32'd0, rd}, 64'd0);
    base = issue_cnt;
    axi_write(8'h04, 32'h0, 4'h0, 0, 0, 0, resp, early, held);
    @(negedge clk);
    check("R1 holding words cleared", last_instr, 64'd0);
    check("R1 issue after reset", 64'(issue_cnt - base), 64'd1);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule